// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block feeds a stereo audio DAC with an unbroken serial sample stream. A host writes 32-bit samples, one at a time, into a left or a right four-word FIFO over a strobe-and-acknowledge bus. The block then sends them out on one serial data line, with a master clock and a left/right word clock that it derives from the system clock.

Each channel has its own shift register. The left register loads from the left FIFO at a fixed point in the frame, and the right register loads from the right FIFO at another fixed point. A multiplexer steered by the word clock phase picks which register drives the data line. An active-low interrupt asks the host for more samples when both FIFOs run low. When a FIFO is empty at its load point, the channel sends a silent word and sets a sticky flag. The host can read that flag back over the same bus.

Top module: `audio_ser_tx`

## Requirements
- R1: After reset `ack_no` is high, `irq_no` is low (both FIFOs empty), `wclk_o` is low and `sdata_o` is 0.
- R2: `mclk_o` toggles on every system clock. `wclk_o` has a period of 512 system clocks: 256 low (left word) then 256 high (right word). A bit period is 8 system clocks, so there are 64 bit slots per frame.
- R3: Slot 0 begins at the falling edge of `wclk_o`. Data is sent MSB first and delayed by one slot. Left bit 31 is in slot 1 and left bit 0 is in slot 32. Right bit 31 is in slot 33 and right bit 0 is in slot 0 of the next frame. `sdata_o` changes only at slot boundaries.
- R4: A write with `chan_sel_i`=0 goes to the left FIFO and one with `chan_sel_i`=1 goes to the right FIFO. Each channel sends its words in the order they were written.
- R5: A strobe held low on `wr_ni` or `rd_ni` is accepted once. `ack_no` goes low for exactly one cycle, in the cycle after the strobe is first sampled low, when the target FIFO is not full.
- R6: Each FIFO holds 4 words. A write to a full FIFO gets no acknowledge and stores nothing. It completes, with its acknowledge, once the channel's next load has freed a place.
- R7: `irq_no` is low when both FIFOs hold 2 or fewer words. It is high when either FIFO holds more than 2. It follows the levels one cycle later.
- R8: If a channel's FIFO is empty at its load point, that channel sends 32 zero bits and its sticky underrun flag is set.
- R9: A read (`rd_ni` low, `wr_ni` high) returns a status word on `data_o`, valid while `ack_no` is low. The fields are: bit 0 = left underrun, bit 1 = right underrun, bits 6:4 = left level, bits 10:8 = right level, all other bits 0. The read clears both underrun flags.
- R10: An underrun in one channel leaves the other channel's data unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_ni | input | 1 | Write strobe, active low, held until acknowledge |
| rd_ni | input | 1 | Status read strobe, active low, held until acknowledge |
| chan_sel_i | input | 1 | Write target: 0 left, 1 right |
| data_i | input | 32 | Sample word to write |
| data_o | output | 32 | Status word returned by a read |
| ack_no | output | 1 | Acknowledge, active low, one cycle |
| irq_no | output | 1 | Refill request, active low |
| mclk_o | output | 1 | Master clock, system clock / 2 |
| wclk_o | output | 1 | Word clock: low for left, high for right |
| sdata_o | output | 1 | Serial audio data |

## Verification
Two situations are the hardest to reach from the ports. One is a write stalled on a full FIFO, which needs the exact moment the load frees a place. The other is an underrun in one channel while the other still has data. The bench aligns its writes to the word clock: it starts them just after the right-channel load, so that no load can happen during a burst. It also writes a different number of words into each channel, so that one runs dry before the other. Captured frames are then decoded slot by slot from the word clock edge. A write is held on a full FIFO until the next left-channel load, and its acknowledge is timed against that load.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  localparam int unsigned CH_L = 0;
  localparam int unsigned CH_R = 1;
  // status word field positions
  localparam int unsigned ST_URUN_L = 0;
  localparam int unsigned ST_URUN_R = 1;
  localparam int unsigned ST_LVL_L  = 4;
  localparam int unsigned ST_LVL_R  = 8;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [LVL_W-1:0] level_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [LVL_W-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == LVL_W'(DEPTH));
  assign level_o = cnt_q;
  assign head_o  = mem_q[rptr_q];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= ptr_inc(wptr_q);
      if (pop_i)  rptr_q <= ptr_inc(rptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= wdata_i;
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk_i) disable iff (!rst_ni) push_i |-> !full_o);  // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) pop_i |-> !empty_o);  // R8
endmodule

// File: rtl/serial_framer.sv
module serial_framer #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned BIT_DIV = 8,
  localparam int unsigned SLOTS  = 2 * WORD_W,
  localparam int unsigned DIV_W  = $clog2(BIT_DIV),
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned CNT_W  = DIV_W + SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] head_l_i,
  input  logic              empty_l_i,
  input  logic [WORD_W-1:0] head_r_i,
  input  logic              empty_r_i,
  output logic              pop_l_o,
  output logic              pop_r_o,
  output logic              urun_l_o,
  output logic              urun_r_o,
  output logic              mclk_o,
  output logic              wclk_o,
  output logic              sdata_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] slot;
  logic              bit_end, load_l, load_r, shift_l, shift_r, sel_r;
  logic [WORD_W-1:0] sr_l_q, sr_r_q;

  assign slot    = cnt_q[CNT_W-1:DIV_W];
  assign bit_end = (cnt_q[DIV_W-1:0] == '1);
  // one-slot delay: left loads at end of slot 0, right at end of slot WORD_W
  assign load_l  = bit_end && (slot == '0);
  assign load_r  = bit_end && (slot == SLOT_W'(WORD_W));
  assign shift_l = bit_end && (slot != '0) && (slot < SLOT_W'(WORD_W));
  assign shift_r = bit_end && (slot > SLOT_W'(WORD_W));
  assign sel_r   = (slot > SLOT_W'(WORD_W)) || (slot == '0);

  assign pop_l_o  = load_l && !empty_l_i;
  assign pop_r_o  = load_r && !empty_r_i;
  assign urun_l_o = load_l && empty_l_i;
  assign urun_r_o = load_r && empty_r_i;

  assign mclk_o  = cnt_q[0];
  assign wclk_o  = cnt_q[CNT_W-1];
  assign sdata_o = sel_r ? sr_r_q[WORD_W-1] : sr_l_q[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sr_l_q <= '0;
      sr_r_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (load_l)       sr_l_q <= empty_l_i ? '0 : head_l_i;
      else if (shift_l) sr_l_q <= {sr_l_q[WORD_W-2:0], 1'b0};
      if (load_r)       sr_r_q <= empty_r_i ? '0 : head_r_i;
      else if (shift_r) sr_r_q <= {sr_r_q[WORD_W-2:0], 1'b0};
    end
  end

  AST_BIT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q[DIV_W-1:0] != '0) |-> $stable(sdata_o));  // R3
  AST_MCLK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (mclk_o != $past(mclk_o)));  // R2
  AST_SILENCE_L: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urun_l_o |=> (sr_l_q == '0));  // R8
  AST_SILENCE_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urun_r_o |=> (sr_r_q == '0));  // R8
  AST_ONE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pop_l_o, pop_r_o, urun_l_o, urun_r_o}));  // R10
endmodule

// File: rtl/host_port.sv
module host_port
  import audio_tx_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LVL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ni,
  input  logic              rd_ni,
  input  logic              chan_sel_i,
  input  logic [1:0]        full_i,
  input  logic [LVL_W-1:0]  lvl_l_i,
  input  logic [LVL_W-1:0]  lvl_r_i,
  input  logic [1:0]        urun_i,
  output logic [1:0]        push_o,
  output logic [WORD_W-1:0] data_o,
  output logic              ack_no
);
  logic       served_q, ack_q, wr_fire, rd_fire;
  logic [1:0] flag_q, flag_now;

  assign wr_fire = !wr_ni && !served_q && !full_i[chan_sel_i];
  assign rd_fire = !rd_ni && wr_ni && !served_q;
  assign push_o[CH_L] = wr_fire && !chan_sel_i;
  assign push_o[CH_R] = wr_fire && chan_sel_i;
  assign flag_now = flag_q | urun_i;
  assign ack_no   = !ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      served_q <= 1'b0;
      ack_q    <= 1'b0;
      flag_q   <= '0;
      data_o   <= '0;
    end else begin
      ack_q <= wr_fire || rd_fire;
      if (wr_ni && rd_ni)          served_q <= 1'b0;
      else if (wr_fire || rd_fire) served_q <= 1'b1;
      // a new underrun in the read cycle survives the clear
      flag_q <= rd_fire ? urun_i : flag_now;
      if (rd_fire) begin
        data_o <= '0;
        data_o[ST_URUN_L] <= flag_now[CH_L];
        data_o[ST_URUN_R] <= flag_now[CH_R];
        data_o[ST_LVL_L +: LVL_W] <= lvl_l_i;
        data_o[ST_LVL_R +: LVL_W] <= lvl_r_i;
      end
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_no |=> ack_no);  // R5
  AST_ACK_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_no) |-> $past(!wr_ni || !rd_ni));  // R5
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[CH_L] && rd_ni) |=> flag_q[CH_L]);  // R8
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import audio_tx_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned IRQ_LVL = 2,
  localparam int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ni,
  input  logic              rd_ni,
  input  logic              chan_sel_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o,
  output logic              ack_no,
  output logic              irq_no,
  output logic              mclk_o,
  output logic              wclk_o,
  output logic              sdata_o
);
  logic [1:0]        push, pop, empty, full, urun;
  logic [WORD_W-1:0] head [2];
  logic [LVL_W-1:0]  lvl  [2];
  logic              irq_q, low_both;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    sample_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) i_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[c]),
      .wdata_i (data_i),
      .pop_i   (pop[c]),
      .head_o  (head[c]),
      .empty_o (empty[c]),
      .full_o  (full[c]),
      .level_o (lvl[c])
    );
  end

  serial_framer #(.WORD_W(WORD_W)) i_framer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .head_l_i  (head[CH_L]),
    .empty_l_i (empty[CH_L]),
    .head_r_i  (head[CH_R]),
    .empty_r_i (empty[CH_R]),
    .pop_l_o   (pop[CH_L]),
    .pop_r_o   (pop[CH_R]),
    .urun_l_o  (urun[CH_L]),
    .urun_r_o  (urun[CH_R]),
    .mclk_o    (mclk_o),
    .wclk_o    (wclk_o),
    .sdata_o   (sdata_o)
  );

  host_port #(.WORD_W(WORD_W), .LVL_W(LVL_W)) i_host (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ni      (wr_ni),
    .rd_ni      (rd_ni),
    .chan_sel_i (chan_sel_i),
    .full_i     (full),
    .lvl_l_i    (lvl[CH_L]),
    .lvl_r_i    (lvl[CH_R]),
    .urun_i     (urun),
    .push_o     (push),
    .data_o     (data_o),
    .ack_no     (ack_no)
  );

  assign low_both = (lvl[CH_L] <= LVL_W'(IRQ_LVL)) && (lvl[CH_R] <= LVL_W'(IRQ_LVL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b1;
    else         irq_q <= low_both;
  end
  assign irq_no = !irq_q;

  AST_IRQ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl[CH_L] > LVL_W'(IRQ_LVL)) |=> irq_no);  // R7
  AST_PUSH_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push[CH_R] |-> (chan_sel_i && !wr_ni));  // R4
endmodule

// File: tb/test_audio_ser_tx.sv
module test_audio_ser_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1, rd_n = 1'b1, csel = 1'b0;
  logic [31:0] din = '0;
  logic [31:0] dout;
  logic        ack_n, irq_n, mclk, wclk, sdata;
  int          checks = 0, errors = 0;
  logic        bits [0:256];

  always #5 clk = ~clk;

  audio_ser_tx i_audio_ser_tx (
    .clk_i(clk), .rst_ni(rst_n), .wr_ni(wr_n), .rd_ni(rd_n), .chan_sel_i(csel),
    .data_i(din), .data_o(dout), .ack_no(ack_n), .irq_no(irq_n),
    .mclk_o(mclk), .wclk_o(wclk), .sdata_o(sdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] status(input bit ul, input bit ur, input int ll, input int lr);
    logic [31:0] s = '0;
    s[0] = ul; s[1] = ur; s[6:4] = 3'(ll); s[10:8] = 3'(lr);
    return s;
  endfunction

  // returns cycles waited for acknowledge
  task automatic host_write(input bit ch, input logic [31:0] d, output int waited);
    @(negedge clk);
    csel = ch; din = d; wr_n = 1'b0;
    waited = 0;
    do begin @(negedge clk); waited++; end while (ack_n && waited < 2000);
    wr_n = 1'b1;
    @(negedge clk);
    chk("R5 ack one cycle", 32'(ack_n), 32'd1);
  endtask

  task automatic host_read(output logic [31:0] st);
    int w = 0;
    @(negedge clk);
    rd_n = 1'b0;
    do begin @(negedge clk); w++; end while (ack_n && w < 2000);
    chk("R9 read ack latency", 32'(w), 32'd1);
    st = dout;
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_wclk(input logic lvl);
    logic prev = wclk;
    forever begin
      @(negedge clk);
      if (wclk == lvl && prev != lvl) break;
      prev = wclk;
    end
  endtask

  // from cnt=0 negedge, sample middle of each slot
  task automatic capture(input int nframes);
    wait_wclk(1'b0);
    for (int k = 0; k <= nframes * 64; k++) begin
      repeat (4) @(negedge clk);
      bits[k] = sdata;
      if (k < 64) chk("R2 wclk phase", 32'(wclk), 32'(k >= 32));
      if (k < nframes * 64) repeat (4) @(negedge clk);
    end
  endtask

  function automatic logic [31:0] word_at(input int first);
    logic [31:0] w;
    for (int i = 0; i < 32; i++) w[31-i] = bits[first + i];
    return w;
  endfunction

  task automatic t_reset;
    #1;
    chk("R1 ack_no", 32'(ack_n), 32'd1);
    chk("R1 irq_no", 32'(irq_n), 32'd0);
    chk("R1 wclk", 32'(wclk), 32'd0);
    chk("R1 sdata", 32'(sdata), 32'd0);
  endtask

  task automatic t_clocks;
    int lo = 0, hi = 0;
    logic m0;
    @(negedge clk); m0 = mclk;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      chk("R2 mclk toggle", 32'(mclk), 32'(m0 ^ logic'(i % 2)));
    end
    wait_wclk(1'b0);
    while (!wclk) begin lo++; @(negedge clk); end
    while (wclk)  begin hi++; @(negedge clk); end
    chk("R2 wclk low", 32'(lo), 32'd256);
    chk("R2 wclk high", 32'(hi), 32'd256);
  endtask

  task automatic t_stream;
    int w;
    logic [31:0] st;
    logic [31:0] lw [3] = '{32'hA5F0_1234, 32'h8000_0001, 32'h0F0F_C3C3};
    logic [31:0] rw [2] = '{32'h1234_5678, 32'hFFFF_0000};
    wait_wclk(1'b1);
    repeat (16) @(negedge clk);
    host_write(1'b0, lw[0], w); chk("R5 write latency", 32'(w), 32'd1);
    host_write(1'b0, lw[1], w);
    host_write(1'b1, rw[0], w);
    host_write(1'b1, rw[1], w);
    chk("R7 irq asserted at 2/2", 32'(irq_n), 32'd0);
    host_write(1'b0, lw[2], w);
    chk("R7 irq released at 3/2", 32'(irq_n), 32'd1);
    capture(3);
    for (int f = 0; f < 3; f++) begin
      chk("R3 R4 left word", word_at(64 * f + 1), lw[f]);
      chk("R3 R4 R10 right word", word_at(64 * f + 33), (f < 2) ? rw[f] : 32'h0);
    end
    chk("R3 slot0 carries prev right lsb", 32'(bits[0]), 32'd0);
    wait_wclk(1'b1);
    host_read(st);
    chk("R8 right underrun flag", 32'(st[1]), 32'd1);
    chk("R8 left underrun flag", 32'(st[0]), 32'd1);
  endtask

  task automatic t_full;
    int w;
    logic [31:0] st;
    wait_wclk(1'b1);
    repeat (16) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      host_write(1'b0, 32'hC000_0000 + 32'(i), w);
      chk("R5 left ack latency", 32'(w), 32'd1);
    end
    for (int i = 0; i < 4; i++) host_write(1'b1, 32'h0300_0000 + 32'(i), w);
    chk("R7 irq released when full", 32'(irq_n), 32'd1);
    host_read(st);
    host_read(st);
    chk("R9 flags cleared, levels 4/4", st, status(0, 0, 4, 4));
    host_write(1'b0, 32'hC000_0004, w);
    chk("R6 stalled write held off", 32'(w > 150), 32'd1);
    chk("R6 stall ends after left load", 32'(wclk), 32'd0);
    host_read(st);
    chk("R6 left refilled to 4", st, status(0, 0, 4, 4));
    capture(1);
    chk("R6 R4 left order after stall", word_at(1), 32'hC000_0001);
    chk("R4 right order", word_at(33), 32'h0300_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_clocks;
    t_stream;
    t_full;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule